// File: doc/BRIEF.md
# Multi-Master I2C Byte Controller

This block is a synchronous I2C bus master. It runs a whole transfer from one command: a Start condition, the address byte, a given number of data bytes each followed by an acknowledge bit, and a Stop condition. The open-drain SCL and SDA lines are never driven high. Each output is an enable that pulls its line low, and the pad releases the line otherwise. The SCL bit period is built from four equal quarters, and each quarter lasts `DIV` system clocks.

The user presents a 7-bit target address, a direction flag and a byte count, with `cmd_valid` high for one cycle while the block is idle. Write bytes are fetched one at a time through `wr_req`. Read bytes come back on `rd_data` with a `rd_valid` pulse. Every acknowledge the block samples is reported on `ack_valid` and `ack_nack`. Other masters may share the bus. While the block intends SDA to be high on an address or write bit, it compares that with the bus level during the SCL-high phase. If the bus is low, it lets go of both lines at once, flags the loss and ends the transfer.

The controller FSM has these states:
- ST_IDLE: both lines released.
- ST_START: SDA falls in the second half of a high SCL period.
- ST_BIT: one of eight data bits.
- ST_ACK: the ninth clock.
- ST_STOP: SDA rises while SCL is high.

The transitions are:
- ST_IDLE to ST_START when a command is accepted.
- ST_START to ST_BIT after one bit period.
- ST_BIT to ST_BIT at each bit boundary.
- ST_BIT to ST_ACK after the eighth bit.
- ST_BIT to ST_IDLE on arbitration loss.
- ST_ACK to ST_BIT when more bytes remain.
- ST_ACK to ST_STOP on the last byte, on a NACK during the address or a write, or when the count is zero after the address.
- ST_STOP to ST_IDLE after the Stop period.

Each byte is tracked by a mode of ADDR, WRITE or READ.

Top module: `i2c_arb_master`

## Requirements
- R1: Out of reset and whenever `busy` is low, `scl_oe` and `sda_oe` are both 0 (lines released), and `done`, `arb_lost` and `nack` read 0 after reset.
- R2: A transfer begins with a Start condition, then the address byte `{cmd_addr, cmd_rw}` sent most significant bit first; bit 0 of that byte is 0 for write and 1 for read.
- R3: Within a byte or acknowledge slot, SDA changes only while SCL is low; each transfer produces exactly one Start (SDA falls with SCL high) and, unless arbitration is lost, exactly one Stop (SDA rises with SCL high).
- R4: On a write, each data byte is taken from `wr_data` in the cycle where `wr_req` is 1, and the bytes appear on the bus in request order, most significant bit first.
- R5: In the ninth clock after the address byte and after each write byte, the sampled SDA level is reported with a one-cycle `ack_valid` pulse, where `ack_nack` = 1 means NACK. A NACK sets the `nack` flag and the transfer ends with a Stop.
- R6: On a read, each byte is shifted in most significant bit first and presented on `rd_data` with a one-cycle `rd_valid` pulse. The master drives ACK (SDA low) after every byte except the last, which it answers with NACK (SDA released) before the Stop.
- R7: A `cmd_len` of 0 sends only the address byte and then a Stop.
- R8: If, on an address or write bit that the master sends as 1, SDA is sampled low while SCL is high, the master releases both lines at once, sets `arb_lost`, pulses `done`, and issues no Stop.
- R9: `arb_lost` and `nack` stay set until the next command is accepted, and are cleared on that acceptance.
- R10: `done` is a single-cycle pulse at the end of every transfer, normal or aborted. It occurs while `busy` is already 0, and `busy` is 1 from the cycle after acceptance until then.
- R11: `cmd_valid` is ignored while `busy` is 1.
- R12: The SCL period is 4*`DIV` system clocks, with SCL low for the first two quarters and high for the last two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a transfer (accepted when idle) |
| cmd_addr | input | 7 | Target address |
| cmd_rw | input | 1 | 0 write, 1 read |
| cmd_len | input | LEN_W | Number of data bytes |
| wr_data | input | 8 | Write byte, sampled when wr_req is 1 |
| wr_req | output | 1 | Current write byte is consumed this cycle |
| rd_data | output | 8 | Last received read byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| ack_valid | output | 1 | An acknowledge bit was sampled |
| ack_nack | output | 1 | Sampled acknowledge level (1 = NACK) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer ended (one cycle) |
| nack | output | 1 | Sticky: a NACK was received |
| arb_lost | output | 1 | Sticky: arbitration was lost |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The hardest situation to reach from the ports is arbitration loss. The block never produces it by itself: a second bus agent has to pull SDA low during exactly the bit where the master releases it, and hold it there across the SCL-high sample point. The bench models that rival as a wired-AND term on the bus, keyed to a chosen bit position of the address byte. It later releases the line and checks that the loss flag stays set until the next command is accepted. The NACK paths are reached through a bus-level target model that refuses either a mismatching address or a chosen write byte.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_STOP
    } st_e;

    typedef enum logic [1:0] {
        MD_ADDR,
        MD_WRITE,
        MD_READ
    } md_e;
endpackage

// File: rtl/i2cm_quarter_tick.sv
module i2cm_quarter_tick #(
    parameter int DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic       tick,
    output logic [1:0] quarter
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            quarter <= 2'd0;
        end else if (!run) begin
            cnt     <= '0;
            quarter <= 2'd0;
        end else if (cnt == LAST) begin
            cnt     <= '0;
            quarter <= quarter + 2'd1;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R12: quarters advance in order and wrap to 0 after quarter 3
    a_r12_quarter_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && quarter == 2'd3) |=> (quarter == 2'd0));
endmodule

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 2'b11;
                else        q <= {scl_in, sda_in};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 2'b11;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign scl_s = g_stage[STAGES-1].q[1];
    assign sda_s = g_stage[STAGES-1].q[0];
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
    import i2cm_pkg::*;
#(
    parameter int DIV   = 8,
    parameter int LEN_W = 4,
    parameter int SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_rw,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_req,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              ack_valid,
    output logic              ack_nack,
    output logic              busy,
    output logic              done,
    output logic              nack,
    output logic              arb_lost,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int MSB      = BYTE_W - 1;
    localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(MSB);
    localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);

    st_e               state, st_n;
    md_e               mode;
    logic [BYTE_W-1:0] shreg, rx;
    logic [CNT_W-1:0]  bitcnt;
    logic [LEN_W-1:0]  rem;
    logic              rw_q, slot_nack;
    logic              nack_q, lost_q, done_q, rdv_q, ackv_q, ackn_q;
    logic              scl_s, sda_s, tick;
    logic [1:0]        quarter;
    logic              at_q2, at_q3, lose, finish, load_wr;
    logic              scl_low_n, sda_low_n;

    i2cm_line_sync #(.STAGES(SYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_i),
        .sda_in (sda_i),
        .scl_s  (scl_s),
        .sda_s  (sda_s)
    );

    i2cm_quarter_tick #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state != ST_IDLE),
        .tick    (tick),
        .quarter (quarter)
    );

    assign at_q2 = tick && (quarter == 2'd2);
    assign at_q3 = tick && (quarter == 2'd3);

    // arbitration: we release SDA (intend 1) on an address/write bit, yet the bus is low while SCL is high
    assign lose = (state == ST_BIT) && at_q2 && (mode != MD_READ)
                  && shreg[MSB] && scl_s && !sda_s;

    always_comb begin
        unique case (mode)
            MD_ADDR:  finish = slot_nack || (rem == '0);
            MD_WRITE: finish = slot_nack || (rem == ONE_LEFT);
            MD_READ:  finish = (rem == ONE_LEFT);
            default:  finish = 1'b1;
        endcase
    end

    assign load_wr = (state == ST_ACK) && at_q3 && !finish
                     && ((mode == MD_WRITE) || ((mode == MD_ADDR) && !rw_q));

    // next-state logic
    always_comb begin
        st_n = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) st_n = ST_START;
            ST_START: if (at_q3) st_n = ST_BIT;
            ST_BIT: begin
                if (lose)                            st_n = ST_IDLE;
                else if (at_q3 && bitcnt == '0)      st_n = ST_ACK;
            end
            ST_ACK:   if (at_q3) st_n = finish ? ST_STOP : ST_BIT;
            ST_STOP:  if (at_q3) st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode      <= MD_ADDR;
            shreg     <= '1;
            rx        <= '0;
            bitcnt    <= '0;
            rem       <= '0;
            rw_q      <= 1'b0;
            slot_nack <= 1'b0;
            nack_q    <= 1'b0;
            lost_q    <= 1'b0;
            done_q    <= 1'b0;
            rdv_q     <= 1'b0;
            ackv_q    <= 1'b0;
            ackn_q    <= 1'b0;
        end else begin
            state  <= st_n;
            done_q <= 1'b0;
            rdv_q  <= 1'b0;
            ackv_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        shreg     <= {cmd_addr, cmd_rw};
                        rw_q      <= cmd_rw;
                        rem       <= cmd_len;
                        mode      <= MD_ADDR;
                        bitcnt    <= TOP_BIT;
                        slot_nack <= 1'b0;
                        nack_q    <= 1'b0;
                        lost_q    <= 1'b0;
                    end
                end
                ST_START: ;
                ST_BIT: begin
                    if (at_q2) begin
                        rx <= {rx[MSB-1:0], sda_s};
                        if (lose) begin
                            lost_q <= 1'b1;
                            done_q <= 1'b1;
                        end
                    end
                    if (at_q3) begin
                        if (bitcnt == '0) begin
                            if (mode == MD_READ) rdv_q <= 1'b1;
                        end else begin
                            bitcnt <= bitcnt - CNT_W'(1);
                            shreg  <= {shreg[MSB-1:0], 1'b1};
                        end
                    end
                end
                ST_ACK: begin
                    if (at_q2) begin
                        slot_nack <= (mode != MD_READ) && sda_s;
                        if (mode != MD_READ) begin
                            ackv_q <= 1'b1;
                            ackn_q <= sda_s;
                            if (sda_s) nack_q <= 1'b1;
                        end
                    end
                    if (at_q3 && !finish) begin
                        bitcnt <= TOP_BIT;
                        if (load_wr) begin
                            shreg <= wr_data;
                            mode  <= MD_WRITE;
                        end else begin
                            shreg <= '1;
                            mode  <= MD_READ;
                        end
                        if (mode != MD_ADDR) rem <= rem - ONE_LEFT;
                    end
                end
                ST_STOP: begin
                    if (at_q3) done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // line drive for the current quarter
    always_comb begin
        scl_low_n = 1'b0;
        sda_low_n = sda_oe;
        unique case (state)
            ST_IDLE: begin
                scl_low_n = 1'b0;
                sda_low_n = 1'b0;
            end
            ST_START: begin
                scl_low_n = 1'b0;
                sda_low_n = quarter[1];
            end
            ST_BIT: begin
                scl_low_n = !quarter[1];
                if (quarter != 2'd0) sda_low_n = (mode != MD_READ) && !shreg[MSB];
            end
            ST_ACK: begin
                scl_low_n = !quarter[1];
                if (quarter != 2'd0) sda_low_n = (mode == MD_READ) && (rem != ONE_LEFT);
            end
            ST_STOP: begin
                scl_low_n = !quarter[1];
                if (quarter != 2'd0) sda_low_n = (quarter != 2'd3);
            end
            default: begin
                scl_low_n = 1'b0;
                sda_low_n = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            scl_oe <= scl_low_n;
            sda_oe <= sda_low_n;
        end
    end

    assign wr_req    = load_wr;
    assign rd_data   = rx;
    assign rd_valid  = rdv_q;
    assign ack_valid = ackv_q;
    assign ack_nack  = ackn_q;
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign nack      = nack_q;
    assign arb_lost  = lost_q;

    // R1: an idle block leaves both lines to the pull-ups
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R3: inside a bit or acknowledge slot SDA moves only while SCL is pulled low
    a_r3_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BIT || state == ST_ACK) && !$stable(sda_oe)) |-> scl_oe);

    // R8: on arbitration loss neither line is being pulled
    a_r8_release_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> (!scl_oe && !sda_oe));

    // R10: done lasts one cycle and only while idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/i2c_arb_master_tb_top.sv
module i2c_arb_master_tb_top;
    localparam int DIV   = 8;
    localparam int LEN_W = 4;
    localparam logic [6:0] SLV = 7'h2A;

    typedef struct packed {
        logic [6:0] a;
        logic       rw;
        logic [3:0] len;
        logic [3:0] nk;
        logic [7:0] base;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{7'h2A, 1'b0, 4'd3, 4'd0, 8'hA5},
        '{7'h2A, 1'b1, 4'd4, 4'd0, 8'h3C},
        '{7'h2A, 1'b0, 4'd4, 4'd2, 8'h0F},
        '{7'h15, 1'b0, 4'd2, 4'd0, 8'h77},
        '{7'h2A, 1'b1, 4'd1, 4'd0, 8'hFF},
        '{7'h2A, 1'b0, 4'd0, 4'd0, 8'h00}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic cmd_rw = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [7:0] wr_data;
    logic wr_req, rd_valid, ack_valid, ack_nack, busy, done, nack, arb_lost;
    logic [7:0] rd_data;
    logic scl_oe, sda_oe, scl_bus, sda_bus;
    logic slave_low = 1'b0;
    logic rival_low;

    int nchk = 0, nerr = 0;
    int starts = 0, stops = 0, bitn = 15, bidx = 0, nseen = 0;
    int rival_bit = -1, nack_at = 0;
    logic [7:0] sh = '0, s_base = '0, cur_base = '0;
    logic s_rw = 1'b0, s_sel = 1'b0;
    logic [7:0] seen [64];
    logic mack [64];
    int dcnt = 0, ackv_cnt = 0, rcnt = 0, wcnt = 0, wc0 = 0;
    logic last_ackn = 1'b0;
    logic [7:0] rlog [64];
    longint pf = 0, per = 0;

    function automatic logic [7:0] wbyte(input logic [7:0] b, input int i);
        return b ^ (8'(i) * 8'h3B);
    endfunction
    function automatic logic [7:0] rbyte(input logic [7:0] b, input int i);
        return b + 8'(i) * 8'h11;
    endfunction

    assign scl_bus   = !scl_oe;
    assign rival_low = (rival_bit >= 0) && (bidx == 0) && (bitn == rival_bit);
    assign sda_bus   = !(sda_oe | slave_low | rival_low);
    assign wr_data   = wbyte(cur_base, wcnt - wc0 + 1);

    i2c_arb_master #(.DIV(DIV), .LEN_W(LEN_W), .SYNC(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_rw(cmd_rw), .cmd_len(cmd_len), .wr_data(wr_data), .wr_req(wr_req),
        .rd_data(rd_data), .rd_valid(rd_valid), .ack_valid(ack_valid),
        .ack_nack(ack_nack), .busy(busy), .done(done), .nack(nack),
        .arb_lost(arb_lost), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // bus-level target model and event monitor
    always @(negedge sda_bus) if (scl_bus === 1'b1) begin
        starts++; bitn = 15; bidx = 0; nseen = 0; s_sel = 1'b0;
    end
    always @(posedge sda_bus) if (scl_bus === 1'b1) begin
        stops++; bitn = 15;
    end
    always @(negedge scl_bus) begin
        logic [7:0] rb;
        per = $time - pf;
        pf  = $time;
        if (bitn == 15) bitn = 0;
        else if (bitn == 8) begin bitn = 0; bidx++; end
        else bitn++;
        slave_low = 1'b0;
        if (s_sel) begin
            if (bitn == 8) slave_low = (bidx == 0) || (!s_rw && bidx != nack_at);
            else if (s_rw && bidx >= 1) begin
                rb = rbyte(s_base, bidx);
                slave_low = !rb[7-bitn];
            end
        end
    end
    always @(posedge scl_bus) begin
        if (bitn < 8) begin
            sh = {sh[6:0], sda_bus};
            if (bitn == 7) begin
                if (nseen < 64) seen[nseen] = sh;
                nseen++;
                if (bidx == 0) begin
                    s_rw  = sh[0];
                    s_sel = (sh[7:1] == SLV);
                end
            end
        end else if (bitn == 8 && s_rw && bidx >= 1) begin
            mack[bidx] = sda_bus;
            if (sda_bus) s_sel = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (done) dcnt++;
        if (ack_valid) begin ackv_cnt++; last_ackn = ack_nack; end
        if (rd_valid) begin
            if (rcnt < 64) rlog[rcnt] = rd_data;
            rcnt++;
        end
    end
    always @(posedge clk) if (wr_req) wcnt <= wcnt + 1;

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [6:0] a, input logic rw, input logic [3:0] len,
                             input logic [7:0] base, input int nk);
        @(negedge clk);
        cur_base = base; s_base = base; nack_at = nk; wc0 = wcnt;
        cmd_addr = a; cmd_rw = rw; cmd_len = len; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        int k;
        k = 0;
        while (dcnt == d0 && k < 20000) begin @(negedge clk); k++; end
        if (k >= 20000) chk("R10 done never seen", 0, 1);
    endtask

    initial begin
        #2000000;
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int s0, p0, d0, a0, r0, eb, ea;
        logic en, sel, el;
        vec_t t;

        repeat (3) @(negedge clk);
        chk("R1 scl_oe in reset", scl_oe, 0);
        chk("R1 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        bitn = 15; starts = 0; stops = 0;
        chk("R1 busy after reset", busy, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 arb_lost after reset", arb_lost, 0);
        chk("R1 nack after reset", nack, 0);
        chk("R1 lines released idle", {scl_oe, sda_oe}, 0);

        for (int v = 0; v < 6; v++) begin
            t = VEC[v];
            s0 = starts; p0 = stops; d0 = dcnt; a0 = ackv_cnt; r0 = rcnt;
            sel = (t.a == SLV);
            if (!sel) begin eb = 1; en = 1'b1; end
            else if (!t.rw && t.nk != 0 && t.nk <= t.len) begin eb = 1 + int'(t.nk); en = 1'b1; end
            else begin eb = 1 + int'(t.len); en = 1'b0; end
            ea = (t.rw && sel) ? 1 : eb;
            el = (t.rw && sel) ? 1'b0 : en;
            start_cmd(t.a, t.rw, t.len, t.base, int'(t.nk));
            chk("R10 busy after accept", busy, 1);
            wait_done(d0);
            repeat (4) @(negedge clk);
            chk("R2 address byte", seen[0], {t.a, t.rw});
            chk("R3 one start", starts - s0, 1);
            chk("R3 one stop", stops - p0, 1);
            chk("R5 bytes on bus", nseen, eb);
            chk("R5 ack reports", ackv_cnt - a0, ea);
            chk("R5 last ack level", last_ackn, el);
            chk("R9 nack flag held", nack, en);
            chk("R10 single done", dcnt - d0, 1);
            chk("R10 busy low at end", busy, 0);
            chk("R8 no arb loss", arb_lost, 0);
            if (!t.rw)
                for (int i = 1; i < eb; i++) chk("R4 write byte", seen[i], wbyte(t.base, i));
            if (t.rw && sel) begin
                chk("R6 read count", rcnt - r0, t.len);
                for (int i = 1; i <= int'(t.len); i++) begin
                    chk("R6 read byte", rlog[r0+i-1], rbyte(t.base, i));
                    chk("R6 master ack level", mack[i], (i == int'(t.len)));
                end
            end
            if (t.len == 0) chk("R7 address only", nseen, 1);
            if (v == 0) chk("R12 SCL period", per, 4 * DIV * 10);
            if (v == 3) begin
                repeat (100) @(negedge clk);
                chk("R9 nack sticky while idle", nack, 1);
            end
        end

        // R11: a second command during a transfer is ignored
        s0 = starts; d0 = dcnt;
        start_cmd(7'h2A, 1'b0, 4'd2, 8'h61, 0);
        repeat (60) @(negedge clk);
        cmd_addr = 7'h55; cmd_rw = 1'b1; cmd_valid = 1'b1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(d0);
        repeat (4) @(negedge clk);
        chk("R11 address unchanged", seen[0], {7'h2A, 1'b0});
        chk("R11 single start", starts - s0, 1);
        chk("R11 single done", dcnt - d0, 1);
        chk("R11 bytes written", nseen, 3);
        repeat (20) @(negedge clk);
        chk("R11 no further transfer", starts - s0, 1);

        // R8: a rival master pulls SDA during the first address bit (sent as 1)
        rival_bit = 0;
        s0 = starts; p0 = stops; d0 = dcnt;
        start_cmd(7'h55, 1'b0, 4'd2, 8'h10, 0);
        wait_done(d0);
        chk("R8 arb_lost set", arb_lost, 1);
        chk("R8 busy dropped", busy, 0);
        chk("R8 lines released", {scl_oe, sda_oe}, 0);
        chk("R8 done on abort", dcnt - d0, 1);
        repeat (4) @(negedge clk);
        chk("R8 no stop from master", stops - p0, 0);
        chk("R8 no byte completed", nseen, 0);
        chk("R8 SCL left high", scl_bus, 1);
        rival_bit = -1;
        repeat (100) @(negedge clk);
        chk("R9 arb_lost sticky", arb_lost, 1);

        // R9: next accepted command clears the flag and runs normally
        d0 = dcnt;
        start_cmd(7'h2A, 1'b0, 4'd1, 8'hC3, 0);
        chk("R9 arb_lost cleared", arb_lost, 0);
        wait_done(d0);
        repeat (4) @(negedge clk);
        chk("R4 write after loss", seen[1], wbyte(8'hC3, 1));
        chk("R9 nack clear", nack, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule